// File: doc/BRIEF.md
# Address-Map Router with Built-In Error Responder

This block sits on the address path of a memory-mapped AXI interconnect, between one manager and a fixed set of subordinate ports. Each write address (AW) and read address (AR) is compared with a parameterised table of regions. Each region has a base and a size. When an address falls in a region, the request, its data beats and its response are steered to that subordinate port. When overlapping regions both cover the address, the region with the smallest index wins.

An address that falls in no region is answered by an error responder inside the block, so the manager never hangs. For a write, the responder takes every data beat and throws it away. After the beat flagged last it gives a single write response carrying the decode-error code. For a read, it produces as many beats as the request's length field plus one. Each beat has zero data and the decode-error code, and only the final beat is flagged last. In both cases the responder copies the request ID into the response ID.

Each direction holds at most one transaction at a time. Writes and reads are tracked separately, so one direction can be busy while the other accepts a new request. Request fields and write data go to every subordinate port at once. Only the valid of the selected port is raised.

Top module: `axi_region_router`

## Requirements
- R1: Response codes are 2 bits wide: OKAY=2'b00, EXOKAY=2'b01, SLVERR=2'b10, DECERR=2'b11. A response from a selected subordinate reaches the manager with its code unchanged.
- R2: A request whose address lies in region i (base <= addr < base+size) raises the address valid of port i only. The manager-side ready then follows that port's ready.
- R3: When regions overlap, the lowest-indexed region that matches is selected. With the defaults, 0x1900 lies in both region 0 and region 1 and goes to port 0.
- R4: An unmapped write raises no subordinate valid on the address or data channel. Every data beat is accepted at once. After the beat with the last flag, exactly one write response is given, with code DECERR and ID equal to the request ID. It stays valid until it is accepted.
- R5: An unmapped read returns request length + 1 beats, each with data 0, code DECERR and ID equal to the request ID. The last flag is set on the final beat only.
- R6: The response code of a routed read is forwarded beat by beat, so a code that changes within one burst appears at the manager on the same beats.
- R7: After a request is accepted in a direction, the address ready of that direction stays low until the final response of that transaction (the write response, or the read beat with the last flag) has been accepted.
- R8: The write and read directions are independent. A read request can be accepted, and its beats can be delivered, in the same cycles as write activity.
- R9: Data beats of a routed write reach the selected port only. Its write response, with that port's ID and code, is returned to the manager.
- R10: While reset is held, and afterwards until a request arrives, no valid is raised toward the manager's response channels or toward any subordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_awvalid | input | 1 | Manager write address valid |
| m_awready | output | 1 | Manager write address ready |
| m_awaddr | input | ADDR_W | Write address |
| m_awid | input | ID_W | Write request ID |
| m_awlen | input | LEN_W | Write burst length minus one |
| m_wvalid | input | 1 | Manager write data valid |
| m_wready | output | 1 | Manager write data ready |
| m_wdata | input | DATA_W | Write data |
| m_wlast | input | 1 | Last write beat |
| m_bvalid | output | 1 | Write response valid |
| m_bready | input | 1 | Write response ready |
| m_bid | output | ID_W | Write response ID |
| m_bresp | output | 2 | Write response code |
| m_arvalid | input | 1 | Manager read address valid |
| m_arready | output | 1 | Manager read address ready |
| m_araddr | input | ADDR_W | Read address |
| m_arid | input | ID_W | Read request ID |
| m_arlen | input | LEN_W | Read burst length minus one |
| m_rvalid | output | 1 | Read beat valid |
| m_rready | input | 1 | Read beat ready |
| m_rdata | output | DATA_W | Read data |
| m_rid | output | ID_W | Read beat ID |
| m_rresp | output | 2 | Read beat response code |
| m_rlast | output | 1 | Last read beat |
| s_awvalid | output | N_SLV | Per-port write address valid |
| s_awready | input | N_SLV | Per-port write address ready |
| s_awaddr | output | ADDR_W | Shared write address |
| s_awid | output | ID_W | Shared write ID |
| s_awlen | output | LEN_W | Shared write length |
| s_wvalid | output | N_SLV | Per-port write data valid |
| s_wready | input | N_SLV | Per-port write data ready |
| s_wdata | output | DATA_W | Shared write data |
| s_wlast | output | 1 | Shared last-beat flag |
| s_bvalid | input | N_SLV | Per-port write response valid |
| s_bready | output | N_SLV | Per-port write response ready |
| s_bid | input | N_SLV*ID_W | Per-port write response IDs |
| s_bresp | input | N_SLV*2 | Per-port write response codes |
| s_arvalid | output | N_SLV | Per-port read address valid |
| s_arready | input | N_SLV | Per-port read address ready |
| s_araddr | output | ADDR_W | Shared read address |
| s_arid | output | ID_W | Shared read ID |
| s_arlen | output | LEN_W | Shared read length |
| s_rvalid | input | N_SLV | Per-port read beat valid |
| s_rready | output | N_SLV | Per-port read beat ready |
| s_rdata | input | N_SLV*DATA_W | Per-port read data |
| s_rid | input | N_SLV*ID_W | Per-port read IDs |
| s_rresp | input | N_SLV*2 | Per-port read response codes |
| s_rlast | input | N_SLV | Per-port last read beat |

## Verification
The error responder serves the write and read directions at the same time, so it can swallow a write data beat and emit a decode-error read beat in the same cycle. A dedicated scenario provokes this. It presents an unmapped write address and an unmapped read address on the same edge and checks that both readies are high together. It then drives the final write beat while the read beat is being taken. The bench judges that cycle by requiring the data ready, the read beat's DECERR code, its ID and its last flag all at once. On the next cycle it requires exactly one DECERR write response and no further read beat.

// File: rtl/axi_dec_pkg.sv
package axi_dec_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } axi_resp_e;

  typedef enum logic [1:0] {
    WPH_IDLE = 2'd0,
    WPH_DATA = 2'd1,
    WPH_RESP = 2'd2
  } wr_phase_e;

  typedef enum logic {
    RPH_IDLE  = 1'b0,
    RPH_BEATS = 1'b1
  } rd_phase_e;
endpackage

// File: rtl/addr_region_match.sv
module addr_region_match #(
  parameter int N_RGN  = 3,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter logic [N_RGN*ADDR_W-1:0] BASES = '0,
  parameter logic [N_RGN*ADDR_W-1:0] SIZES = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [N_RGN-1:0] in_rgn;

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    localparam logic [ADDR_W-1:0] RBASE = BASES[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] RSIZE = SIZES[g*ADDR_W +: ADDR_W];
    logic [ADDR_W-1:0] offs;
    assign offs      = addr - RBASE;
    assign in_rgn[g] = (offs < RSIZE);
  end

  // scan from the top down so the lowest matching index is left last
  always_comb begin
    hit = |in_rgn;
    idx = '0;
    for (int k = N_RGN - 1; k >= 0; k--) begin
      if (in_rgn[k]) idx = k[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/wr_route.sv
module wr_route
  import axi_dec_pkg::*;
#(
  parameter int N_SLV = 3,
  parameter int ID_W  = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hit,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  m_awvalid,
  output logic                  m_awready,
  input  logic [ID_W-1:0]       m_awid,
  input  logic                  m_wvalid,
  output logic                  m_wready,
  input  logic                  m_wlast,
  output logic                  m_bvalid,
  input  logic                  m_bready,
  output logic [ID_W-1:0]       m_bid,
  output logic [1:0]            m_bresp,
  output logic [N_SLV-1:0]      s_awvalid,
  input  logic [N_SLV-1:0]      s_awready,
  output logic [N_SLV-1:0]      s_wvalid,
  input  logic [N_SLV-1:0]      s_wready,
  input  logic [N_SLV-1:0]      s_bvalid,
  output logic [N_SLV-1:0]      s_bready,
  input  logic [N_SLV*ID_W-1:0] s_bid,
  input  logic [N_SLV*2-1:0]    s_bresp
);
  wr_phase_e        phase_q;
  logic [IDX_W-1:0] sel_q;
  logic             dflt_q;
  logic [ID_W-1:0]  id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= WPH_IDLE;
      sel_q   <= '0;
      dflt_q  <= 1'b0;
      id_q    <= '0;
    end else begin
      case (phase_q)
        WPH_IDLE: if (m_awvalid && m_awready) begin
          phase_q <= WPH_DATA;
          sel_q   <= idx;
          dflt_q  <= !hit;
          id_q    <= m_awid;
        end
        WPH_DATA: if (m_wvalid && m_wready && m_wlast) phase_q <= WPH_RESP;
        WPH_RESP: if (m_bvalid && m_bready) phase_q <= WPH_IDLE;
        default:  phase_q <= WPH_IDLE;
      endcase
    end
  end

  always_comb begin
    m_awready = 1'b0;
    m_wready  = 1'b0;
    m_bvalid  = 1'b0;
    m_bid     = '0;
    m_bresp   = RSP_OKAY;
    s_awvalid = '0;
    s_wvalid  = '0;
    s_bready  = '0;
    case (phase_q)
      WPH_IDLE: begin
        s_awvalid[idx] = m_awvalid & hit;
        m_awready      = hit ? s_awready[idx] : 1'b1;
      end
      WPH_DATA: begin
        if (dflt_q) begin
          m_wready = 1'b1;
        end else begin
          s_wvalid[sel_q] = m_wvalid;
          m_wready        = s_wready[sel_q];
        end
      end
      WPH_RESP: begin
        if (dflt_q) begin
          m_bvalid = 1'b1;
          m_bid    = id_q;
          m_bresp  = RSP_DECERR;
        end else begin
          m_bvalid        = s_bvalid[sel_q];
          s_bready[sel_q] = m_bready;
          m_bid           = s_bid[sel_q*ID_W +: ID_W];
          m_bresp         = s_bresp[sel_q*2 +: 2];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rd_route.sv
module rd_route
  import axi_dec_pkg::*;
#(
  parameter int N_SLV  = 3,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hit,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    m_arvalid,
  output logic                    m_arready,
  input  logic [ID_W-1:0]         m_arid,
  input  logic [LEN_W-1:0]        m_arlen,
  output logic                    m_rvalid,
  input  logic                    m_rready,
  output logic [DATA_W-1:0]       m_rdata,
  output logic [ID_W-1:0]         m_rid,
  output logic [1:0]              m_rresp,
  output logic                    m_rlast,
  output logic [N_SLV-1:0]        s_arvalid,
  input  logic [N_SLV-1:0]        s_arready,
  input  logic [N_SLV-1:0]        s_rvalid,
  output logic [N_SLV-1:0]        s_rready,
  input  logic [N_SLV*DATA_W-1:0] s_rdata,
  input  logic [N_SLV*ID_W-1:0]   s_rid,
  input  logic [N_SLV*2-1:0]      s_rresp,
  input  logic [N_SLV-1:0]        s_rlast
);
  rd_phase_e        phase_q;
  logic [IDX_W-1:0] sel_q;
  logic             dflt_q;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= RPH_IDLE;
      sel_q   <= '0;
      dflt_q  <= 1'b0;
      id_q    <= '0;
      left_q  <= '0;
    end else begin
      case (phase_q)
        RPH_IDLE: if (m_arvalid && m_arready) begin
          phase_q <= RPH_BEATS;
          sel_q   <= idx;
          dflt_q  <= !hit;
          id_q    <= m_arid;
          left_q  <= m_arlen;
        end
        RPH_BEATS: begin
          if (m_rvalid && m_rready) begin
            if (m_rlast) phase_q <= RPH_IDLE;
            else if (dflt_q) left_q <= left_q - 1'b1;
          end
        end
        default: phase_q <= RPH_IDLE;
      endcase
    end
  end

  always_comb begin
    m_arready = 1'b0;
    m_rvalid  = 1'b0;
    m_rdata   = '0;
    m_rid     = '0;
    m_rresp   = RSP_OKAY;
    m_rlast   = 1'b0;
    s_arvalid = '0;
    s_rready  = '0;
    case (phase_q)
      RPH_IDLE: begin
        s_arvalid[idx] = m_arvalid & hit;
        m_arready      = hit ? s_arready[idx] : 1'b1;
      end
      RPH_BEATS: begin
        if (dflt_q) begin
          m_rvalid = 1'b1;
          m_rid    = id_q;
          m_rresp  = RSP_DECERR;
          m_rlast  = (left_q == '0);
        end else begin
          m_rvalid        = s_rvalid[sel_q];
          s_rready[sel_q] = m_rready;
          m_rdata         = s_rdata[sel_q*DATA_W +: DATA_W];
          m_rid           = s_rid[sel_q*ID_W +: ID_W];
          m_rresp         = s_rresp[sel_q*2 +: 2];
          m_rlast         = s_rlast[sel_q];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/axi_region_router.sv
module axi_region_router #(
  parameter int N_SLV  = 3,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter logic [N_SLV*ADDR_W-1:0] REGION_BASE = {32'h0000_8000, 32'h0000_1800, 32'h0000_1000},
  parameter logic [N_SLV*ADDR_W-1:0] REGION_SIZE = {32'h0000_1000, 32'h0000_2000, 32'h0000_1000}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    m_awvalid,
  output logic                    m_awready,
  input  logic [ADDR_W-1:0]       m_awaddr,
  input  logic [ID_W-1:0]         m_awid,
  input  logic [LEN_W-1:0]        m_awlen,
  input  logic                    m_wvalid,
  output logic                    m_wready,
  input  logic [DATA_W-1:0]       m_wdata,
  input  logic                    m_wlast,
  output logic                    m_bvalid,
  input  logic                    m_bready,
  output logic [ID_W-1:0]         m_bid,
  output logic [1:0]              m_bresp,
  input  logic                    m_arvalid,
  output logic                    m_arready,
  input  logic [ADDR_W-1:0]       m_araddr,
  input  logic [ID_W-1:0]         m_arid,
  input  logic [LEN_W-1:0]        m_arlen,
  output logic                    m_rvalid,
  input  logic                    m_rready,
  output logic [DATA_W-1:0]       m_rdata,
  output logic [ID_W-1:0]         m_rid,
  output logic [1:0]              m_rresp,
  output logic                    m_rlast,
  output logic [N_SLV-1:0]        s_awvalid,
  input  logic [N_SLV-1:0]        s_awready,
  output logic [ADDR_W-1:0]       s_awaddr,
  output logic [ID_W-1:0]         s_awid,
  output logic [LEN_W-1:0]        s_awlen,
  output logic [N_SLV-1:0]        s_wvalid,
  input  logic [N_SLV-1:0]        s_wready,
  output logic [DATA_W-1:0]       s_wdata,
  output logic                    s_wlast,
  input  logic [N_SLV-1:0]        s_bvalid,
  output logic [N_SLV-1:0]        s_bready,
  input  logic [N_SLV*ID_W-1:0]   s_bid,
  input  logic [N_SLV*2-1:0]      s_bresp,
  output logic [N_SLV-1:0]        s_arvalid,
  input  logic [N_SLV-1:0]        s_arready,
  output logic [ADDR_W-1:0]       s_araddr,
  output logic [ID_W-1:0]         s_arid,
  output logic [LEN_W-1:0]        s_arlen,
  input  logic [N_SLV-1:0]        s_rvalid,
  output logic [N_SLV-1:0]        s_rready,
  input  logic [N_SLV*DATA_W-1:0] s_rdata,
  input  logic [N_SLV*ID_W-1:0]   s_rid,
  input  logic [N_SLV*2-1:0]      s_rresp,
  input  logic [N_SLV-1:0]        s_rlast
);
  localparam int IDX_W = (N_SLV > 1) ? $clog2(N_SLV) : 1;

  logic             aw_hit, ar_hit;
  logic [IDX_W-1:0] aw_idx, ar_idx;

  // request fields and write data fan out to every port; only valids are steered
  assign s_awaddr = m_awaddr;
  assign s_awid   = m_awid;
  assign s_awlen  = m_awlen;
  assign s_wdata  = m_wdata;
  assign s_wlast  = m_wlast;
  assign s_araddr = m_araddr;
  assign s_arid   = m_arid;
  assign s_arlen  = m_arlen;

  addr_region_match #(
    .N_RGN(N_SLV), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .BASES(REGION_BASE), .SIZES(REGION_SIZE)
  ) u_aw_match (
    .addr(m_awaddr), .hit(aw_hit), .idx(aw_idx)
  );

  addr_region_match #(
    .N_RGN(N_SLV), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .BASES(REGION_BASE), .SIZES(REGION_SIZE)
  ) u_ar_match (
    .addr(m_araddr), .hit(ar_hit), .idx(ar_idx)
  );

  wr_route #(.N_SLV(N_SLV), .ID_W(ID_W), .IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst(rst), .hit(aw_hit), .idx(aw_idx),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bid(m_bid), .m_bresp(m_bresp),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp)
  );

  rd_route #(
    .N_SLV(N_SLV), .ID_W(ID_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk(clk), .rst(rst), .hit(ar_hit), .idx(ar_idx),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_arid(m_arid), .m_arlen(m_arlen),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rid(m_rid),
    .m_rresp(m_rresp), .m_rlast(m_rlast),
    .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rid(s_rid),
    .s_rresp(s_rresp), .s_rlast(s_rlast)
  );
endmodule

// File: rtl/axi_region_router_chk.sv
module axi_region_router_chk #(
  parameter int N_SLV  = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [1:0]        m_bresp,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic [1:0]        m_rresp,
  input logic [DATA_W-1:0] m_rdata,
  input logic              m_rlast,
  input logic [N_SLV-1:0]  s_awvalid,
  input logic [N_SLV-1:0]  s_wvalid,
  input logic [N_SLV-1:0]  s_arvalid,
  input logic [N_SLV-1:0]  s_bvalid,
  input logic [N_SLV-1:0]  s_rvalid
);
  logic wr_open, rd_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_open <= 1'b0;
      rd_open <= 1'b0;
    end else begin
      if (m_awvalid && m_awready) wr_open <= 1'b1;
      else if (m_bvalid && m_bready) wr_open <= 1'b0;
      if (m_arvalid && m_arready) rd_open <= 1'b1;
      else if (m_rvalid && m_rready && m_rlast) rd_open <= 1'b0;
    end
  end

  assert_aw_single_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_awvalid) && $onehot0(s_arvalid));

  assert_w_single_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_wvalid));

  assert_dflt_bresp_R4: assert property (@(posedge clk) disable iff (rst)
    (m_bvalid && s_bvalid == '0) |-> (m_bresp == 2'b11));

  assert_dflt_bhold_R4: assert property (@(posedge clk) disable iff (rst)
    (m_bvalid && !m_bready && s_bvalid == '0) |=> m_bvalid);

  assert_dflt_rbeat_R5: assert property (@(posedge clk) disable iff (rst)
    (m_rvalid && s_rvalid == '0) |-> (m_rresp == 2'b11 && m_rdata == '0));

  assert_dflt_rhold_R5: assert property (@(posedge clk) disable iff (rst)
    (m_rvalid && !m_rready && s_rvalid == '0) |=> (m_rvalid && $stable(m_rlast)));

  assert_wr_single_outstanding_R7: assert property (@(posedge clk) disable iff (rst)
    wr_open |-> !m_awready);

  assert_rd_single_outstanding_R7: assert property (@(posedge clk) disable iff (rst)
    rd_open |-> !m_arready);
endmodule

bind axi_region_router axi_region_router_chk #(.N_SLV(N_SLV), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
  .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rresp(m_rresp),
  .m_rdata(m_rdata), .m_rlast(m_rlast),
  .s_awvalid(s_awvalid), .s_wvalid(s_wvalid), .s_arvalid(s_arvalid),
  .s_bvalid(s_bvalid), .s_rvalid(s_rvalid)
);

// File: tb/sim_axi_region_router.sv
module sim_axi_region_router;
  localparam int N  = 3;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int DW = 32;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic m_awvalid = 0, m_awready;
  logic [AW-1:0] m_awaddr = '0;
  logic [IW-1:0] m_awid = '0;
  logic [LW-1:0] m_awlen = '0;
  logic m_wvalid = 0, m_wready, m_wlast = 0;
  logic [DW-1:0] m_wdata = '0;
  logic m_bvalid, m_bready = 0;
  logic [IW-1:0] m_bid;
  logic [1:0] m_bresp;
  logic m_arvalid = 0, m_arready;
  logic [AW-1:0] m_araddr = '0;
  logic [IW-1:0] m_arid = '0;
  logic [LW-1:0] m_arlen = '0;
  logic m_rvalid, m_rready = 0, m_rlast;
  logic [DW-1:0] m_rdata;
  logic [IW-1:0] m_rid;
  logic [1:0] m_rresp;
  logic [N-1:0] s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
  logic [N-1:0] s_awready = '1, s_wready = '1, s_arready = '1;
  logic [N-1:0] s_bvalid = '0, s_rvalid = '0, s_rlast = '0;
  logic [AW-1:0] s_awaddr, s_araddr;
  logic [IW-1:0] s_awid, s_arid;
  logic [LW-1:0] s_awlen, s_arlen;
  logic [DW-1:0] s_wdata;
  logic s_wlast;
  logic [N*IW-1:0] s_bid = '0, s_rid = '0;
  logic [N*2-1:0] s_bresp = '0, s_rresp = '0;
  logic [N*DW-1:0] s_rdata = '0;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  axi_region_router u0 (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R10", "bvalid in reset", m_bvalid, 0);
    chk("R10", "rvalid in reset", m_rvalid, 0);
    rst = 0;
    @(negedge clk); #1;
    chk("R10", "sub valids idle", {s_awvalid, s_wvalid, s_arvalid}, 0);
    chk("R10", "bvalid idle", m_bvalid, 0);
    chk("R10", "rvalid idle", m_rvalid, 0);
  endtask

  task automatic t_routed_write(input logic [AW-1:0] addr, input int port,
                                input logic [IW-1:0] id, input logic [IW-1:0] sid,
                                input logic [1:0] code);
    @(negedge clk);
    m_awvalid = 1; m_awaddr = addr; m_awid = id; m_awlen = 1;
    #1;
    chk("R2/R3", "awvalid port select", s_awvalid, 1 << port);
    chk("R2", "awready follows port", m_awready, 1);
    @(posedge clk);
    @(negedge clk);
    m_awvalid = 0; m_wvalid = 1; m_wlast = 0; m_wdata = 32'hA5A5_0001;
    #1;
    chk("R9", "wvalid port select", s_wvalid, 1 << port);
    chk("R7", "awready low while busy", m_awready, 0);
    @(posedge clk);
    @(negedge clk);
    m_wlast = 1; m_wdata = 32'hA5A5_0002;
    @(posedge clk);
    @(negedge clk);
    m_wvalid = 0; m_wlast = 0; m_bready = 1;
    s_bvalid[port] = 1; s_bid[port*IW +: IW] = sid; s_bresp[port*2 +: 2] = code;
    #1;
    chk("R9", "bvalid forwarded", m_bvalid, 1);
    chk("R9", "bid from port", m_bid, sid);
    chk("R1", "bresp unchanged", m_bresp, code);
    @(posedge clk);
    @(negedge clk);
    s_bvalid = '0; m_bready = 0;
    #1;
    chk("R7", "awready back after B", m_awready, 1);
  endtask

  task automatic t_unmapped_write(input logic [AW-1:0] addr, input logic [IW-1:0] id, input int beats);
    @(negedge clk);
    m_awvalid = 1; m_awaddr = addr; m_awid = id; m_awlen = LW'(beats - 1);
    #1;
    chk("R4", "no sub awvalid", s_awvalid, 0);
    chk("R4", "default awready", m_awready, 1);
    @(posedge clk);
    for (int k = 0; k < beats; k++) begin
      @(negedge clk);
      m_awvalid = 0; m_wvalid = 1; m_wlast = (k == beats - 1); m_wdata = 32'h1234_0000 + k;
      #1;
      chk("R4", "wbeat swallowed", {m_wready, s_wvalid}, {1'b1, 3'b000});
      chk("R4", "no early B", m_bvalid, 0);
      chk("R7", "awready low in data", m_awready, 0);
      @(posedge clk);
    end
    @(negedge clk);
    m_wvalid = 0; m_wlast = 0;
    #1;
    chk("R4", "B valid", m_bvalid, 1);
    chk("R4", "B code DECERR", m_bresp, 2'b11);
    chk("R4", "B id echo", m_bid, id);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R4", "B held while not ready", m_bvalid, 1);
    m_bready = 1;
    @(posedge clk);
    @(negedge clk);
    m_bready = 0;
    #1;
    chk("R4", "single B only", m_bvalid, 0);
  endtask

  task automatic t_unmapped_read(input logic [AW-1:0] addr, input logic [IW-1:0] id, input int len);
    @(negedge clk);
    m_arvalid = 1; m_araddr = addr; m_arid = id; m_arlen = LW'(len);
    #1;
    chk("R5", "no sub arvalid", s_arvalid, 0);
    chk("R5", "default arready", m_arready, 1);
    @(posedge clk);
    @(negedge clk);
    m_arvalid = 0; m_rready = 1;
    for (int k = 0; k <= len; k++) begin
      #1;
      chk("R5", "beat valid", m_rvalid, 1);
      chk("R5", "beat data zero", m_rdata, 0);
      chk("R5", "beat DECERR", m_rresp, 2'b11);
      chk("R5", "beat id", m_rid, id);
      chk("R5", "last flag", m_rlast, (k == len));
      if (k == 0) chk("R7", "arready low in burst", m_arready, 0);
      @(posedge clk);
      @(negedge clk);
    end
    m_rready = 0;
    #1;
    chk("R5", "no extra beat", m_rvalid, 0);
  endtask

  task automatic t_routed_read(input logic [AW-1:0] addr, input int port, input logic [IW-1:0] id);
    logic [1:0] codes [3] = '{2'b00, 2'b10, 2'b00};
    @(negedge clk);
    m_arvalid = 1; m_araddr = addr; m_arid = id; m_arlen = 2;
    #1;
    chk("R2", "arvalid port select", s_arvalid, 1 << port);
    @(posedge clk);
    @(negedge clk);
    m_arvalid = 0; m_rready = 1;
    for (int k = 0; k < 3; k++) begin
      s_rvalid[port] = 1; s_rid[port*IW +: IW] = id;
      s_rdata[port*DW +: DW] = 32'hBEEF_0000 + k;
      s_rresp[port*2 +: 2] = codes[k]; s_rlast[port] = (k == 2);
      #1;
      chk("R6", "per-beat code", m_rresp, codes[k]);
      chk("R6", "per-beat data", m_rdata, 32'hBEEF_0000 + k);
      chk("R6", "last forwarded", m_rlast, (k == 2));
      @(posedge clk);
      @(negedge clk);
    end
    s_rvalid = '0; s_rlast = '0; m_rready = 0;
    #1;
    chk("R7", "arready back after last", m_arready, 1);
  endtask

  task automatic t_concurrent();
    @(negedge clk);
    m_awvalid = 1; m_awaddr = 32'h0000_5000; m_awid = 4'h5; m_awlen = 0;
    m_arvalid = 1; m_araddr = 32'h0000_6000; m_arid = 4'h6; m_arlen = 0;
    #1;
    chk("R8", "both readies", {m_awready, m_arready}, 2'b11);
    @(posedge clk);
    @(negedge clk);
    m_awvalid = 0; m_arvalid = 0; m_wvalid = 1; m_wlast = 1; m_rready = 1;
    #1;
    chk("R8", "wready with R beat", m_wready, 1);
    chk("R8", "R beat same cycle", {m_rvalid, m_rresp, m_rlast, m_rid}, {1'b1, 2'b11, 1'b1, 4'h6});
    @(posedge clk);
    @(negedge clk);
    m_wvalid = 0; m_wlast = 0; m_rready = 0; m_bready = 1;
    #1;
    chk("R8", "B after concurrent", {m_bvalid, m_bresp, m_bid}, {1'b1, 2'b11, 4'h5});
    chk("R8", "read finished", m_rvalid, 0);
    @(posedge clk);
    @(negedge clk);
    m_bready = 0;
    #1;
    chk("R8", "write finished", m_bvalid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_routed_write(32'h0000_1010, 0, 4'h1, 4'h9, 2'b00);
    t_routed_write(32'h0000_1900, 0, 4'h2, 4'hA, 2'b10);   // R3 overlap
    t_routed_write(32'h0000_2800, 1, 4'h3, 4'hB, 2'b10);
    t_unmapped_write(32'h0000_4000, 4'h7, 3);
    t_unmapped_write(32'hFFFF_0000, 4'hC, 1);
    t_unmapped_read(32'h0000_9000, 4'h4, 3);
    t_unmapped_read(32'h0000_0000, 4'hD, 0);
    t_routed_read(32'h0000_8010, 2, 4'hE);
    t_routed_read(32'h0000_1FFC, 0, 4'h8);                 // R3 overlap
    t_concurrent();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule